// File: doc/BRIEF.md
# Command List Sequencer Channel

This block is one channel of a multi-channel command engine. Software places a list of 32-bit command words in memory, loads the byte address of the first word into the start-address register, and then sets the run flag in the control/status register. The channel reads each command word and its operand words one at a time over a single-outstanding read port. When a command is fully fetched, the channel raises a ready request to a shared arbiter. On the one-cycle grant it executes that command and then moves on to the next one.

Two command kinds exist. A store command carries a target address and a data word and issues one write strobe. A branch command carries one word that replaces the fetch pointer. A run ends in one of three ways: a command completes with its stop flag set, a fetch returns an error or an undefined command kind, or software drops the run flag. The hardware reports the end of a run by clearing the run flag itself. It can also pulse an interrupt when the run ends on a stop flag. A list can run indefinitely, for example a branch back to an earlier command.

Top module: `cmd_chan_seq`

## Requirements
- R1: After reset the status word reads zero, and memReq, arbReady, irq and memWr are all low.
- R2: Writing 1 to the run flag (status bit 0) while idle makes the first read go to the full 32-bit start address. Later reads follow at successive addresses 4 bytes apart, and each request holds its address until memRvalid.
- R3: arbReady is high only after every word of a command has been read and never together with memReq. It stays high with no execution until arbGrant, and it drops after the grant.
- R4: A store command (kind field [31:28] = 0) is followed by an address word and a data word. One grant produces exactly one single-cycle memWr carrying those two words.
- R5: Without a flow change, the next command word is read from the address just past the last operand word of the previous command.
- R6: A branch command (kind field = 1) is followed by one target word. The next command word is read from that target address.
- R7: A command with bit 27 (stop) set ends the run when it executes: the run flag reads 0 and no further reads are issued.
- R8: If the stopping command also has bit 26 set, irq pulses for exactly one cycle, in the same cycle the run flag clears. A stop with bit 26 clear gives no pulse.
- R9: A command word with any other kind value sets status bits [2:1] to 1, clears the run flag, and gives no execution, no irq and no further reads.
- R10: A read completed with memRerr high sets status bits [2:1] to 2, clears the run flag, and gives no execution and no irq.
- R11: If software writes 0 to the run flag during a run, the channel finishes at most the command in progress, then stops with no irq.
- R12: Starting a run clears the error code in status bits [2:1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrWe | input | 1 | Write strobe for the start-address register |
| addrWdata | input | 32 | New start address |
| cfgWe | input | 1 | Write strobe for the run flag |
| cfgStartIn | input | 1 | Value written to the run flag |
| cfgRdata | output | 32 | Status: bit 0 run flag, bits [2:1] error code |
| memReq | output | 1 | Read request, held until memRvalid |
| memAddr | output | 32 | Read byte address |
| memRvalid | input | 1 | Read completes this cycle |
| memRdata | input | 32 | Read data |
| memRerr | input | 1 | Read completed with an error |
| arbReady | output | 1 | A fully fetched command waits for a grant |
| arbGrant | input | 1 | One-cycle execution grant |
| memWr | output | 1 | Single-cycle write strobe from a store command |
| memWaddr | output | 32 | Write address |
| memWdata | output | 32 | Write data |
| irq | output | 1 | One-cycle end-of-run interrupt pulse |

## Verification
Four single-store-and-stop lists are tried first. They differ in address, data and interrupt flag, which separates the write path from the irq gating, and they include all-ones and all-zeros data. A two-command list and a branch-then-store list show sequential fetch apart from redirected fetch; the exact order of read addresses is checked. An unbounded branch loop is stopped by software, and a withheld grant shows that execution waits on the arbiter. An undefined command kind and an operand bus error show the two error codes apart, and a restart afterwards shows that the code clears.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

  localparam logic [3:0] OP_WRITE = 4'd0;
  localparam logic [3:0] OP_JUMP  = 4'd1;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_BADOP = 2'd1;
  localparam logic [1:0] ERR_BUS   = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_READY = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPc;
    logic incPc;
    logic capCmd;
    logic capOpA;
    logic capOpB;
    logic doJump;
    logic doWrite;
  } dpCtrl_t;

endpackage

// File: rtl/cmd_seq_dp.sv
module cmd_seq_dp
  import cmd_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpc,
  input  logic              addrWe,
  input  logic [WORD_W-1:0] addrWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [3:0]        cmdOp,
  output logic              cmdStop,
  output logic              cmdIe,
  output logic              memWr,
  output logic [WORD_W-1:0] memWaddr,
  output logic [WORD_W-1:0] memWdata
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int OP_LSB     = WORD_W - 4;
  localparam int STOP_POS   = WORD_W - 5;
  localparam int IE_POS     = WORD_W - 6;

  logic [WORD_W-1:0] startAddrQ;
  logic [WORD_W-1:0] pcQ;
  logic [WORD_W-1:0] opAQ;
  logic [WORD_W-1:0] opBQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddrQ <= '0;
    end else if (addrWe) begin
      startAddrQ <= addrWdata;
    end
  end

  // fetch pointer: start load, then branch, then sequential step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (dpc.loadPc) begin
      pcQ <= startAddrQ;
    end else if (dpc.doJump) begin
      pcQ <= opAQ;
    end else if (dpc.incPc) begin
      pcQ <= pcQ + WORD_W'(WORD_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOp   <= '0;
      cmdStop <= 1'b0;
      cmdIe   <= 1'b0;
      opAQ    <= '0;
      opBQ    <= '0;
    end else begin
      if (dpc.capCmd) begin
        cmdOp   <= memRdata[OP_LSB +: 4];
        cmdStop <= memRdata[STOP_POS];
        cmdIe   <= memRdata[IE_POS];
      end
      if (dpc.capOpA) opAQ <= memRdata;
      if (dpc.capOpB) opBQ <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWr    <= 1'b0;
      memWaddr <= '0;
      memWdata <= '0;
    end else begin
      memWr <= dpc.doWrite;
      if (dpc.doWrite) begin
        memWaddr <= opAQ;
        memWdata <= opBQ;
      end
    end
  end

  assign memAddr = pcQ;

  // R4: the write strobe is a single cycle
  assert_write_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> !memWr);

endmodule

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
  import cmd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       cfgStartIn,
  input  logic       memRvalid,
  input  logic       memRerr,
  input  logic [3:0] fetchOp,
  input  logic       arbGrant,
  input  logic [3:0] cmdOp,
  input  logic       cmdStop,
  input  logic       cmdIe,
  output logic       memReq,
  output logic       arbReady,
  output logic       startBit,
  output logic [1:0] errCode,
  output logic       irq,
  output dpCtrl_t    dpc
);

  seqState_e stateQ, stateD;
  logic [1:0] idxQ, idxD;
  logic       startD;
  logic [1:0] errD;
  logic       irqD;
  logic [1:0] needWords;

  assign needWords = (cmdOp == OP_JUMP) ? 2'd1 : 2'd2;

  always_comb begin
    stateD = stateQ;
    idxD   = idxQ;
    startD = startBit;
    errD   = errCode;
    irqD   = 1'b0;
    dpc    = '0;
    if (cfgWe) startD = cfgStartIn;
    case (stateQ)
      ST_IDLE: begin
        if (cfgWe && cfgStartIn) begin
          dpc.loadPc = 1'b1;
          errD       = ERR_NONE;
          idxD       = 2'd0;
          stateD     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (memRvalid) begin
          if (memRerr) begin
            errD   = ERR_BUS;
            startD = 1'b0;
            stateD = ST_IDLE;
          end else if (idxQ == 2'd0) begin
            if (fetchOp == OP_WRITE || fetchOp == OP_JUMP) begin
              dpc.capCmd = 1'b1;
              dpc.incPc  = 1'b1;
              idxD       = 2'd1;
            end else begin
              errD   = ERR_BADOP;
              startD = 1'b0;
              stateD = ST_IDLE;
            end
          end else begin
            dpc.incPc  = 1'b1;
            dpc.capOpA = (idxQ == 2'd1);
            dpc.capOpB = (idxQ == 2'd2);
            if (idxQ == needWords) begin
              idxD   = 2'd0;
              stateD = ST_READY;
            end else begin
              idxD = idxQ + 2'd1;
            end
          end
        end
      end
      ST_READY: begin
        if (arbGrant) begin
          dpc.doWrite = (cmdOp == OP_WRITE);
          dpc.doJump  = (cmdOp == OP_JUMP);
          if (cmdStop || !startD) begin
            irqD   = cmdStop && cmdIe && startD;
            startD = 1'b0;
            stateD = ST_IDLE;
          end else begin
            stateD = ST_FETCH;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      idxQ     <= '0;
      startBit <= 1'b0;
      errCode  <= ERR_NONE;
      irq      <= 1'b0;
    end else begin
      stateQ   <= stateD;
      idxQ     <= idxD;
      startBit <= startD;
      errCode  <= errD;
      irq      <= irqD;
    end
  end

  assign memReq   = (stateQ == ST_FETCH);
  assign arbReady = (stateQ == ST_READY);

  // R3: no ready while fetching, and a grant retires the ready command
  assert_ready_excl_fetch_R3: assert property (@(posedge clk) disable iff (!rstN)
    arbReady |-> !memReq);
  assert_grant_retires_R3: assert property (@(posedge clk) disable iff (!rstN)
    (arbReady && arbGrant) |=> !arbReady);
  // R8: interrupt is a one-cycle pulse coinciding with a cleared run flag
  assert_irq_start_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !startBit);
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R9: a new error leaves the channel stopped
  assert_error_halts_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errCode != ERR_NONE) |-> (!startBit && !memReq && !arbReady));

endmodule

// File: rtl/cmd_chan_seq.sv
module cmd_chan_seq
  import cmd_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWe,
  input  logic [WORD_W-1:0] addrWdata,
  input  logic              cfgWe,
  input  logic              cfgStartIn,
  output logic [WORD_W-1:0] cfgRdata,
  output logic              memReq,
  output logic [WORD_W-1:0] memAddr,
  input  logic              memRvalid,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memRerr,
  output logic              arbReady,
  input  logic              arbGrant,
  output logic              memWr,
  output logic [WORD_W-1:0] memWaddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              irq
);

  dpCtrl_t    dpc;
  logic [3:0] cmdOp;
  logic       cmdStop;
  logic       cmdIe;
  logic       startBit;
  logic [1:0] errCode;

  cmd_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgStartIn (cfgStartIn),
    .memRvalid  (memRvalid),
    .memRerr    (memRerr),
    .fetchOp    (memRdata[WORD_W-1 -: 4]),
    .arbGrant   (arbGrant),
    .cmdOp      (cmdOp),
    .cmdStop    (cmdStop),
    .cmdIe      (cmdIe),
    .memReq     (memReq),
    .arbReady   (arbReady),
    .startBit   (startBit),
    .errCode    (errCode),
    .irq        (irq),
    .dpc        (dpc)
  );

  cmd_seq_dp #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpc       (dpc),
    .addrWe    (addrWe),
    .addrWdata (addrWdata),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .cmdOp     (cmdOp),
    .cmdStop   (cmdStop),
    .cmdIe     (cmdIe),
    .memWr     (memWr),
    .memWaddr  (memWaddr),
    .memWdata  (memWdata)
  );

  assign cfgRdata = {{(WORD_W-3){1'b0}}, errCode, startBit};

  // R2: a pending read keeps its address until it completes
  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRvalid) |=> (memReq && $stable(memAddr)));

endmodule

// File: tb/cmd_chan_seq_tb.sv
`timescale 1ns/1ps
module cmd_chan_seq_tb_top;

  localparam logic [31:0] BASE = 32'hA5C0_0000;

  localparam logic [31:0] V_ADDR [4] = '{32'h4000_1000, 32'h4000_2004, 32'hFFFF_FFFC, 32'h0000_0008};
  localparam logic [31:0] V_DATA [4] = '{32'hDEAD_BEEF, 32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFF};
  localparam bit          V_IE   [4] = '{1'b1, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrWe = 1'b0;
  logic [31:0] addrWdata = '0;
  logic        cfgWe = 1'b0;
  logic        cfgStartIn = 1'b0;
  logic [31:0] cfgRdata;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRvalid = 1'b0;
  logic [31:0] memRdata = '0;
  logic        memRerr = 1'b0;
  logic        arbReady;
  logic        arbGrant = 1'b0;
  logic        memWr;
  logic [31:0] memWaddr;
  logic [31:0] memWdata;
  logic        irq;

  always #2.5 clk = ~clk;

  cmd_chan_seq dut_i (
    .clk(clk), .rstN(rstN), .addrWe(addrWe), .addrWdata(addrWdata),
    .cfgWe(cfgWe), .cfgStartIn(cfgStartIn), .cfgRdata(cfgRdata),
    .memReq(memReq), .memAddr(memAddr), .memRvalid(memRvalid),
    .memRdata(memRdata), .memRerr(memRerr), .arbReady(arbReady),
    .arbGrant(arbGrant), .memWr(memWr), .memWaddr(memWaddr),
    .memWdata(memWdata), .irq(irq)
  );

  logic [31:0] mem [32];
  logic [31:0] errAddr = '0;
  bit          errOn = 1'b0;
  bit          grantOn = 1'b1;
  int          fetchN = 0, wrN = 0, irqN = 0;
  logic [31:0] fetchLog [64];
  logic [31:0] wrAddrLog [8];
  logic [31:0] wrDataLog [8];
  int          checkN = 0, failN = 0;

  // memory, arbiter and monitor, all acting on the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      memRvalid = 1'b0;
      arbGrant  = 1'b0;
    end else begin
      if (memRvalid) begin
        memRvalid = 1'b0;
      end else if (memReq) begin
        memRvalid = 1'b1;
        memRdata  = mem[memAddr[6:2]];
        memRerr   = errOn && (memAddr == errAddr);
        if (fetchN < 64) fetchLog[fetchN] = memAddr;
        fetchN++;
      end
      if (arbGrant) arbGrant = 1'b0;
      else if (arbReady && grantOn) arbGrant = 1'b1;
      if (memWr) begin
        if (wrN < 8) begin
          wrAddrLog[wrN] = memWaddr;
          wrDataLog[wrN] = memWdata;
        end
        wrN++;
      end
      if (irq) irqN++;
    end
  end

  function automatic logic [31:0] mk(logic [3:0] op, logic stop, logic ie);
    return {op, stop, ie, 26'd0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checkN++;
    if (act !== exp) begin
      failN++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cfgWr(bit v);
    @(negedge clk); cfgWe = 1'b1; cfgStartIn = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic run(logic [31:0] a);
    fetchN = 0; wrN = 0; irqN = 0;
    @(negedge clk); addrWe = 1'b1; addrWdata = a;
    @(negedge clk); addrWe = 1'b0;
    cfgWr(1'b1);
  endtask

  task automatic waitDone();
    for (int k = 0; k < 400; k++) begin
      if (!cfgRdata[0]) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkN, failN);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkN++; failN++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mem[i*3]   = mk(4'h0, 1'b1, V_IE[i]);
      mem[i*3+1] = V_ADDR[i];
      mem[i*3+2] = V_DATA[i];
    end
    mem[12] = mk(4'h7, 1'b1, 1'b1);
    mem[13] = mk(4'h0, 1'b0, 1'b0); mem[14] = 32'h5000_0000; mem[15] = 32'h1111_1111;
    mem[16] = mk(4'h0, 1'b1, 1'b1); mem[17] = 32'h5000_0004; mem[18] = 32'h2222_2222;
    mem[19] = mk(4'h1, 1'b0, 1'b0); mem[20] = BASE + 32'd96;
    for (int i = 21; i < 24; i++) mem[i] = mk(4'hF, 1'b1, 1'b0);
    mem[24] = mk(4'h0, 1'b1, 1'b1); mem[25] = 32'h6000_0000; mem[26] = 32'hCAFE_F00D;
    mem[27] = mk(4'h0, 1'b0, 1'b1); mem[28] = 32'h7000_0000; mem[29] = 32'h3333_3333;
    mem[30] = mk(4'h1, 1'b0, 1'b0); mem[31] = BASE + 32'd108;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", cfgRdata, 32'd0, "status after reset");
    chk("R1", {memReq, arbReady, irq, memWr}, 4'b0000, "outputs after reset");

    // table walk: single store with stop, varied data and interrupt flag
    for (int i = 0; i < 4; i++) begin
      run(BASE + 32'(i*12));
      waitDone();
      chk("R2", fetchLog[0], BASE + 32'(i*12), "first fetch address");
      chk("R4", wrN, 1, "write count");
      chk("R4", wrAddrLog[0], V_ADDR[i], "write address");
      chk("R4", wrDataLog[0], V_DATA[i], "write data");
      chk("R7", {cfgRdata[2:0], memReq}, 4'b0000, "stopped, no error");
      chk("R7", fetchN, 3, "no reads after stop");
      chk("R8", irqN, V_IE[i] ? 1 : 0, "irq pulses");
    end

    // R5 two sequential commands
    run(BASE + 32'd52);
    waitDone();
    chk("R5", wrN, 2, "two writes");
    chk("R5", wrDataLog[0], 32'h1111_1111, "first write data");
    chk("R5", wrAddrLog[1], 32'h5000_0004, "second write address");
    chk("R5", fetchLog[3], BASE + 32'd64, "next command address");
    chk("R2", fetchLog[5], BASE + 32'd72, "last read address");
    chk("R8", irqN, 1, "irq from stopping command");

    // R6 branch
    run(BASE + 32'd76);
    waitDone();
    chk("R6", fetchN, 5, "reads with branch");
    chk("R6", fetchLog[2], BASE + 32'd96, "read after branch");
    chk("R6", wrDataLog[0], 32'hCAFE_F00D, "write at target");
    chk("R6", {cfgRdata[2:0]}, 3'b000, "clean end");

    // R3 grant withheld
    grantOn = 1'b0;
    run(BASE + 32'd12);
    repeat (30) @(negedge clk);
    chk("R3", {arbReady, memReq}, 2'b10, "waiting for grant");
    chk("R3", wrN, 0, "no execution without grant");
    grantOn = 1'b1;
    waitDone();
    chk("R3", wrN, 1, "executed after grant");

    // R9 undefined command kind
    run(BASE + 32'd48);
    waitDone();
    chk("R9", cfgRdata[2:0], 3'b010, "bad kind status");
    chk("R9", {fetchN, wrN, irqN}, {32'd1, 32'd0, 32'd0}, "reads/writes/irqs");

    // R10 bus error on the operand read
    errOn = 1'b1; errAddr = BASE + 32'd4;
    run(BASE);
    waitDone();
    errOn = 1'b0;
    chk("R10", cfgRdata[2:0], 3'b100, "bus error status");
    chk("R10", {fetchN, wrN, irqN}, {32'd2, 32'd0, 32'd0}, "reads/writes/irqs");

    // R12 restart clears error
    run(BASE);
    chk("R12", cfgRdata[2:0], 3'b001, "running with error cleared");
    waitDone();
    chk("R12", wrN, 1, "rerun completes");

    // R11 unbounded loop halted by software
    run(BASE + 32'd108);
    repeat (80) @(negedge clk);
    chk("R11", (wrN >= 3) ? 1 : 0, 1, "loop keeps running");
    grantOn = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (arbReady) break;
      @(negedge clk);
    end
    begin
      int w0;
      w0 = wrN;
      cfgWr(1'b0);
      chk("R11", cfgRdata[0], 1'b0, "run flag cleared by software");
      grantOn = 1'b1;
      repeat (30) @(negedge clk);
      chk("R11", ((wrN - w0) <= 1) ? 1 : 0, 1, "at most one more command");
    end
    chk("R11", {memReq, arbReady, cfgRdata[2:0]}, 5'b00000, "halted");
    chk("R11", irqN, 0, "no irq on software halt");

    summary();
    $finish;
  end

endmodule